// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Gray Encoder

This block sits behind a bank of flash-converter comparators. It turns their thermometer-coded word into an n-bit Gray code and into the matching binary value. It does not search for the highest comparator that reads 1. Each Gray bit is formed from a few local transition terms, and each term looks for a 1 at one comparator and a 0 at a comparator a fixed distance above it. A single stray 1 near the top of the bank then moves the result by no more than one code.

For comparison, the block also outputs a plain highest-one priority index of the same word. This output shows the large jump that the Gray path avoids.

A word is sampled into an input register whenever the sample strobe is high. Gray, binary and priority results appear in output registers on the next clock, together with a one-cycle valid pulse. The results hold between samples. The default configuration is n = 4, which takes a 15-bit comparator word.

Top module: `therm_gray_enc`

## Requirements
- R1: Comparator j (1 to 15) drives `cmpWord` bit j-1. For a clean thermometer word with the lowest L bits set (L = 0..15), `binOut` equals L exactly. All zeros gives 0 and all ones gives 15.
- R2: For a clean thermometer word of level L, `grayOut` equals L XOR (L >> 1).
- R3: For clean words of levels L-1 and L, the `grayOut` values differ in exactly one bit.
- R4: For any word, `binOut` is the Gray-to-binary value of `grayOut`. Bit 3 is copied, and each lower bit is the XOR of the binary bit above it and the Gray bit at its own position. Equivalently, `binOut` XOR (`binOut` >> 1) equals `grayOut`.
- R5: `prioOut` is the number (1 to 15) of the highest comparator that reads 1, or 0 when none does.
- R6: A clean word of level L (0 to 14) with a stray 1 added on comparator 15 gives `binOut` within one code of L. With 7 true ones plus that stray, `prioOut` reads 15 while `binOut` reads 6 or 7.
- R7: A word presented with `cmpValid` high at clock edge k is reported after edge k+1, with `outValid` high for exactly that one cycle.
- R8: While no sample is taken, `outValid` stays low and `grayOut`, `binOut` and `prioOut` hold their values, even when `cmpWord` changes.
- R9: A synchronous active-high `rst` clears `grayOut`, `binOut`, `prioOut` and `outValid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpValid | input | 1 | Sample strobe for `cmpWord` |
| cmpWord | input | 15 | Comparator outputs; bit j-1 is comparator j |
| grayOut | output | 4 | Gray code of the sampled level |
| binOut | output | 4 | Binary value decoded from `grayOut` |
| prioOut | output | 4 | Highest-one index of the sampled word |
| outValid | output | 1 | One-cycle pulse marking new results |

## Verification
The bench targets the transition terms at both ends of the range. A start or partner index that is off by one would break the all-ones or all-zeros code, and it would also break the single-bit Gray steps between neighbouring levels. A stray 1 on the top comparator is injected over every level. A design that used the priority search on the Gray path would jump to 15 there instead of staying within one code. The bench also changes the comparator word with the strobe low and re-checks the outputs, to catch registers that load without a strobe or a valid pulse that lasts more than one cycle.

// File: rtl/therm_gray_pkg.sv
package therm_gray_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic captureEn;   // load the comparator word register
    logic updateEn;    // load the result registers
  } enc_strobe_t;

endpackage

// File: rtl/therm_gray_ctrl.sv
module therm_gray_ctrl
  import therm_gray_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmpValid,
  output enc_strobe_t strobes,
  output logic        outValid
);

  logic stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= cmpValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobes.captureEn = cmpValid;
    strobes.updateEn  = stageValid;
  end

  // R7: a sample produces a valid pulse two edges later
  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
    cmpValid |=> ##1 outValid);

  // R8: no pulse without a sample taken two edges earlier
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !cmpValid |=> ##1 !outValid);

endmodule

// File: rtl/therm_gray_dp.sv
module therm_gray_dp
  import therm_gray_pkg::*;
#(
  parameter int RES_BITS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  enc_strobe_t         strobes,
  input  logic [(1<<RES_BITS)-2:0] cmpWord,
  output logic [RES_BITS-1:0] grayOut,
  output logic [RES_BITS-1:0] binOut,
  output logic [RES_BITS-1:0] prioOut
);

  localparam int NUM_CMP = (1 << RES_BITS) - 1;

  logic [NUM_CMP-1:0]  wordReg;
  logic [RES_BITS-1:0] grayNext;
  logic [RES_BITS-1:0] binNext;
  logic [RES_BITS-1:0] prioNext;

  always_ff @(posedge clk) begin
    if (rst)                    wordReg <= '0;
    else if (strobes.captureEn) wordReg <= cmpWord;
  end

  // Top Gray bit: the mid-scale comparator alone
  assign grayNext[RES_BITS-1] = wordReg[(1 << (RES_BITS-1)) - 1];

  // Lower Gray bits: OR of (one at start) AND (zero at start + 2^(k+1))
  for (genvar k = 0; k < RES_BITS-1; k++) begin : g_grayBit
    localparam int STEP  = 1 << (k + 2);
    localparam int FIRST = 1 << k;
    localparam int SPAN  = 1 << (k + 1);
    localparam int TERMS = 1 << (RES_BITS - k - 2);
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int m = 0; m < TERMS; m++) begin
        acc = acc | (wordReg[FIRST + m*STEP - 1] & ~wordReg[FIRST + m*STEP + SPAN - 1]);
      end
    end
    assign grayNext[k] = acc;
  end

  // Gray to binary, MSB downward
  always_comb begin
    binNext[RES_BITS-1] = grayNext[RES_BITS-1];
    for (int k = RES_BITS-2; k >= 0; k--) begin
      binNext[k] = binNext[k+1] ^ grayNext[k];
    end
  end

  // Reference highest-one search
  always_comb begin
    prioNext = '0;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (wordReg[i]) prioNext = RES_BITS'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grayOut <= '0;
      binOut  <= '0;
      prioOut <= '0;
    end else if (strobes.updateEn) begin
      grayOut <= grayNext;
      binOut  <= binNext;
      prioOut <= prioNext;
    end
  end

  // R1: on a clean thermometer word the Gray path agrees with the search
  assert_clean_match_R1: assert property (@(posedge clk) disable iff (rst)
    (strobes.updateEn && ((wordReg & (wordReg + 1'b1)) == '0)) |=> (binOut == prioOut));

  // R4: binary output re-encodes to the Gray output
  assert_bin_gray_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.updateEn |=> ((binOut ^ (binOut >> 1)) == grayOut));

  // R8: results hold when no update strobe
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.updateEn |=> ($stable(grayOut) && $stable(binOut) && $stable(prioOut)));

endmodule

// File: rtl/therm_gray_enc.sv
module therm_gray_enc
  import therm_gray_pkg::*;
#(
  parameter int RES_BITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmpValid,
  input  logic [(1<<RES_BITS)-2:0]    cmpWord,
  output logic [RES_BITS-1:0]         grayOut,
  output logic [RES_BITS-1:0]         binOut,
  output logic [RES_BITS-1:0]         prioOut,
  output logic                        outValid
);

  enc_strobe_t strobes;

  therm_gray_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .cmpValid (cmpValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  therm_gray_dp #(.RES_BITS(RES_BITS)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cmpWord (cmpWord),
    .grayOut (grayOut),
    .binOut  (binOut),
    .prioOut (prioOut)
  );

  // R9: first cycle after reset shows cleared outputs
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!outValid && grayOut == '0 && binOut == '0 && prioOut == '0));

endmodule

// File: tb/therm_gray_enc_tb_top.sv
module therm_gray_enc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmpValid = 1'b0;
  logic [14:0] cmpWord = '0;
  logic [3:0]  grayOut, binOut, prioOut;
  logic        outValid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  therm_gray_enc dut_i (
    .clk(clk), .rst(rst), .cmpValid(cmpValid), .cmpWord(cmpWord),
    .grayOut(grayOut), .binOut(binOut), .prioOut(prioOut), .outValid(outValid)
  );

  // {comparator word, level}
  localparam logic [18:0] VECS [0:15] = '{
    {15'h0000, 4'd0},  {15'h0001, 4'd1},  {15'h0003, 4'd2},  {15'h0007, 4'd3},
    {15'h000F, 4'd4},  {15'h001F, 4'd5},  {15'h003F, 4'd6},  {15'h007F, 4'd7},
    {15'h00FF, 4'd8},  {15'h01FF, 4'd9},  {15'h03FF, 4'd10}, {15'h07FF, 4'd11},
    {15'h0FFF, 4'd12}, {15'h1FFF, 4'd13}, {15'h3FFF, 4'd14}, {15'h7FFF, 4'd15}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one sample; return at the falling edge after results are registered
  task automatic sample(input logic [14:0] w);
    @(negedge clk);
    cmpWord  = w;
    cmpValid = 1'b1;
    @(negedge clk);
    cmpValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] prevGray;
    logic [3:0] hGray, hBin, hPrio;
    int lvl, diff;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid == 1'b0, "R9 valid", outValid, 0);
    check(grayOut == 4'd0 && binOut == 4'd0 && prioOut == 4'd0, "R9 outputs",
          {grayOut, binOut, prioOut}, 0);
    rst = 1'b0;

    prevGray = '0;
    for (int i = 0; i < 16; i++) begin
      lvl = int'(VECS[i][3:0]);
      sample(VECS[i][18:4]);
      check(outValid == 1'b1, "R7 valid pulse", outValid, 1);
      check(binOut == 4'(lvl), "R1 clean level", binOut, lvl);
      check(grayOut == 4'(lvl ^ (lvl >> 1)), "R2 gray code", grayOut, lvl ^ (lvl >> 1));
      check((binOut ^ (binOut >> 1)) == grayOut, "R4 gray-to-binary", binOut, grayOut);
      check(prioOut == 4'(lvl), "R5 priority clean", prioOut, lvl);
      if (i > 0)
        check($countones(grayOut ^ prevGray) == 1, "R3 one-bit step",
              $countones(grayOut ^ prevGray), 1);
      prevGray = grayOut;
      @(negedge clk);
      check(outValid == 1'b0, "R7 single pulse", outValid, 0);
    end

    // R6: stray one on comparator 15 over each level
    for (int l = 0; l < 15; l++) begin
      sample(15'((32'd1 << l) - 1) | 15'h4000);
      diff = int'(binOut) - l;
      check(diff >= -1 && diff <= 1, "R6 top bubble", binOut, l);
      check(prioOut == 4'd15, "R5 priority bubble", prioOut, 15);
      check((binOut ^ (binOut >> 1)) == grayOut, "R4 bubble decode", binOut, grayOut);
    end

    // R6 / R5: seven ones plus stray on top
    sample(15'h407F);
    check(binOut == 4'd6 || binOut == 4'd7, "R6 seven plus stray", binOut, 7);
    check(prioOut == 4'd15, "R5 seven plus stray", prioOut, 15);

    // R5: scattered ones
    sample(15'h0105);
    check(prioOut == 4'd9, "R5 scattered", prioOut, 9);
    check((binOut ^ (binOut >> 1)) == grayOut, "R4 scattered", binOut, grayOut);

    // R8: word changes with no strobe
    sample(15'h001F);
    hGray = grayOut; hBin = binOut; hPrio = prioOut;
    @(negedge clk);
    cmpWord = 15'h7FFF;
    repeat (4) begin
      @(negedge clk);
      check(outValid == 1'b0, "R8 no valid", outValid, 0);
      check(grayOut == hGray && binOut == hBin && prioOut == hPrio, "R8 hold",
            binOut, hBin);
    end

    // R9: mid-run reset
    sample(15'h3FFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(grayOut == 4'd0 && binOut == 4'd0 && prioOut == 4'd0, "R9 mid reset",
          {grayOut, binOut, prioOut}, 0);
    check(outValid == 1'b0, "R9 mid reset valid", outValid, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule